// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Bank

This block keeps two bits of state for every external interrupt line: an enable bit and a pending bit. Software reaches them over a plain 32-bit register port (word address, write data, write strobe, combinational read data). Each kind of state has one register region where writing ones sets bits and a second region where writing ones clears bits. Zeros written to any region change nothing.

Hardware requests arrive on one input per line. A per-line two-state edge machine turns each rising request into a one-cycle pulse that sets the pending bit. The bit stays set while the line is disabled and while the downstream arbiter is busy elsewhere. The block presents `pend & enable` for every line to the priority arbiter. When the arbiter accepts a line, it returns that line's index on the acknowledge port and the pending bit drops. The source may raise its request again later.

Line index 0 in this block is the first external interrupt, number 16 in the system numbering. Line n sits in word n/32, bit n%32, of every region.

Each request edge machine has two states. REQ_LOW means the request was last seen low, and REQ_HIGH means it was last seen high. Transition `rise` goes from REQ_LOW to REQ_HIGH when the request is 1, and it emits the set pulse. Transition `fall` goes from REQ_HIGH to REQ_LOW when the request is 0. In every other case the machine holds its state.

Top module: `irq_enpend_bank`

## Requirements
- R1: After reset every enable bit and every pending bit is 0, every register reads 0 and `irq_ready` is 0.
- R2: A write to the enable-set region (address bits [4:3] = 0, word in bits [2:0]) sets each enable bit whose data bit is 1. Bits written 0 keep their value.
- R3: A write to the enable-clear region (address bits [4:3] = 1) clears each enable bit whose data bit is 1. Bits written 0 keep their value.
- R4: A write to the pend-set region (address bits [4:3] = 2) sets each pending bit whose data bit is 1. Bits written 0 keep their value.
- R5: A write to the pend-clear region (address bits [4:3] = 3) clears each pending bit whose data bit is 1, discarding the stored request. Bits written 0 keep their value.
- R6: A 0-to-1 change on `irq_req[n]` sets pending bit n at the next clock edge. A request held high does not set the bit again after it has been cleared. A fresh low-then-high change sets it again.
- R7: A pending bit is kept while its line is disabled. `irq_ready[n]` is 1 exactly when pending bit n and enable bit n are both 1.
- R8: `ack_valid` with `ack_line = n` clears pending bit n at the next edge. An index of `NUM_LINES` or above changes nothing.
- R9: When a set (request edge or pend-set write) and a clear (pend-clear write or acknowledge) reach the same pending bit in one cycle, the bit ends up 1.
- R10: Reading either region of a pair returns the current state of that pair: enable for regions 0 and 1, pending for regions 2 and 3. Line n reads at word n/32, bit n%32. Bits above the last line read 0.
- R11: A word index at or beyond `ceil(NUM_LINES/32)` reads 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Word address: region in the top two bits, word below |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | input | NUM_LINES | Raw request per line, synchronous to `clk` |
| ack_valid | input | 1 | Arbiter accepted a line this cycle |
| ack_line | input | IDX_W | Index of the accepted line |
| irq_ready | output | NUM_LINES | Pending and enabled, per line |

## Verification
The bench builds the block with its defaults, `NUM_LINES = 40` and `ADDR_W = 5`. This gives a full first word and a second word where only bits 0 to 7 are live. With these values, the unused upper bits of the second word, an unmapped third word, and an acknowledge index above the last line can all be reached. Same-cycle collisions between request edges, pend-set writes, pend-clear writes and acknowledges are driven on chosen lines in both words, and the result is read back through the register port.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int unsigned REG_W = 32;

    // Register region, taken from the top two word-address bits
    typedef enum logic [1:0] {
        RG_EN_SET   = 2'd0,
        RG_EN_CLR   = 2'd1,
        RG_PEND_SET = 2'd2,
        RG_PEND_CLR = 2'd3
    } reg_region_e;

    // Per-line request edge machine
    typedef enum logic {
        REQ_LOW  = 1'b0,
        REQ_HIGH = 1'b1
    } req_state_e;

endpackage

// File: rtl/irq_req_edge.sv
module irq_req_edge
    import irq_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic rise
);

    req_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_LOW:  if (req)  state_d = REQ_HIGH;
            REQ_HIGH: if (!req) state_d = REQ_LOW;
            default:            state_d = REQ_LOW;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= REQ_LOW;
        else        state_q <= state_d;
    end

    // Output logic: pulse on the rise transition only
    always_comb begin
        rise = 1'b0;
        unique case (state_q)
            REQ_LOW:  rise = req;
            REQ_HIGH: rise = 1'b0;
            default:  rise = 1'b0;
        endcase
    end

    // R6: a set pulse never lasts two cycles
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_bank_pkg::*;
#(
    parameter int unsigned NUM_LINES = 40,
    parameter int unsigned ADDR_W    = 5
) (
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [REG_W-1:0]     wdata,
    input  logic [NUM_LINES-1:0] en_q,
    input  logic [NUM_LINES-1:0] pend_q,
    output logic [NUM_LINES-1:0] en_set,
    output logic [NUM_LINES-1:0] en_clr,
    output logic [NUM_LINES-1:0] pend_wset,
    output logic [NUM_LINES-1:0] pend_wclr,
    output logic [REG_W-1:0]     rdata
);

    localparam int unsigned NWORDS = (NUM_LINES + REG_W - 1) / REG_W;
    localparam int unsigned WSEL_W = ADDR_W - 2;
    localparam int unsigned FLAT   = NWORDS * REG_W;

    reg_region_e             region;
    logic [WSEL_W-1:0]       word;
    logic [NUM_LINES-1:0]    wr_bits;
    logic [FLAT-1:0]         en_w;
    logic [FLAT-1:0]         pend_w;
    logic [FLAT-1:0]         src;

    assign region = reg_region_e'(addr[ADDR_W-1 -: 2]);
    assign word   = addr[WSEL_W-1:0];

    // R11: a line takes write data only when its own word is addressed
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line_wr
        assign wr_bits[n] = wr_en && (word == WSEL_W'(n / REG_W)) && wdata[n % REG_W];
    end

    always_comb begin
        en_set    = '0;
        en_clr    = '0;
        pend_wset = '0;
        pend_wclr = '0;
        unique case (region)
            RG_EN_SET:   en_set    = wr_bits;
            RG_EN_CLR:   en_clr    = wr_bits;
            RG_PEND_SET: pend_wset = wr_bits;
            RG_PEND_CLR: pend_wclr = wr_bits;
            default: ;
        endcase
    end

    // R10: both regions of a pair read the same state
    assign en_w   = FLAT'(en_q);
    assign pend_w = FLAT'(pend_q);

    always_comb begin
        src   = ((region == RG_PEND_SET) || (region == RG_PEND_CLR)) ? pend_w : en_w;
        rdata = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (word == WSEL_W'(w)) rdata = src[w*REG_W +: REG_W];
        end
    end

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank #(
    parameter int unsigned NUM_LINES = 40,
    parameter int unsigned IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] en_set,
    input  logic [NUM_LINES-1:0] en_clr,
    input  logic [NUM_LINES-1:0] pend_set,
    input  logic [NUM_LINES-1:0] pend_clr,
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_idx,
    output logic [NUM_LINES-1:0] en_q,
    output logic [NUM_LINES-1:0] pend_q
);

    logic [NUM_LINES-1:0] ack_vec;
    logic [NUM_LINES-1:0] pend_kill;

    // R8: an out-of-range index shifts the one out and clears nothing
    assign ack_vec   = ack_valid ? (NUM_LINES'(1) << ack_idx) : '0;
    assign pend_kill = pend_clr | ack_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            en_q   <= (en_q & ~en_clr) | en_set;
            // R9: set is applied after clear, so set wins
            pend_q <= (pend_q & ~pend_kill) | pend_set;
        end
    end

    // R2
    a_r2_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set != '0) |=> ((en_q & $past(en_set)) == $past(en_set)));

    // R3
    a_r3_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_clr & ~en_set) != '0) |=> ((en_q & $past(en_clr & ~en_set)) == '0));

    // R5
    a_r5_unpend: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_clr & ~pend_set) != '0) |=> ((pend_q & $past(pend_clr & ~pend_set)) == '0));

    // R8
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_vec & ~pend_set) != '0) |=> ((pend_q & $past(ack_vec & ~pend_set)) == '0));

    // R9
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_set != '0) |=> ((pend_q & $past(pend_set)) == $past(pend_set)));

endmodule

// File: rtl/irq_enpend_bank.sv
module irq_enpend_bank
    import irq_bank_pkg::*;
#(
    parameter int unsigned NUM_LINES = 40,
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [NUM_LINES-1:0] irq_req,
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_line,
    output logic [NUM_LINES-1:0] irq_ready
);

    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] en_q, pend_q;
    logic [NUM_LINES-1:0] en_set, en_clr, pend_wset, pend_wclr;

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_edge
        irq_req_edge i_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (irq_req[n]),
            .rise (rise[n])
        );
    end

    irq_bus_decode #(
        .NUM_LINES(NUM_LINES),
        .ADDR_W   (ADDR_W)
    ) i_decode (
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .en_q     (en_q),
        .pend_q   (pend_q),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .pend_wset(pend_wset),
        .pend_wclr(pend_wclr),
        .rdata    (bus_rdata)
    );

    irq_state_bank #(
        .NUM_LINES(NUM_LINES),
        .IDX_W    (IDX_W)
    ) i_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .pend_set (pend_wset | rise),
        .pend_clr (pend_wclr),
        .ack_valid(ack_valid),
        .ack_idx  (ack_line),
        .en_q     (en_q),
        .pend_q   (pend_q)
    );

    // R7
    assign irq_ready = pend_q & en_q;

    // R7: a disabled line never reaches the arbiter
    a_r7_ready_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr != '0) |=> ((irq_ready & $past(en_clr)) == '0));

endmodule

// File: tb/test_irq_enpend_bank.sv
module test_irq_enpend_bank;

    localparam int unsigned NL = 40;
    localparam logic [4:0] ES = 5'd0, EC = 5'd8, PS = 5'd16, PC = 5'd24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NL-1:0] irq_req = '0;
    logic        ack_valid = 1'b0;
    logic [5:0]  ack_line = '0;
    logic [NL-1:0] irq_ready;

    logic [NL-1:0] en_m = '0, pend_m = '0;
    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    irq_enpend_bank i_irq_enpend_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
        .ack_valid(ack_valid), .ack_line(ack_line), .irq_ready(irq_ready));

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // R10: compare both regions of each pair with the model
    task automatic check_state(input string tag);
        logic [31:0] d;
        logic [63:0] flat_en, flat_pd;
        flat_en = 64'(en_m);
        flat_pd = 64'(pend_m);
        rd(ES, d);     check({tag, " R10 en w0 set-rd"}, 64'(d), 64'(flat_en[31:0]));
        rd(EC + 1, d); check({tag, " R10 en w1 clr-rd"}, 64'(d), 64'(flat_en[63:32]));
        rd(PC, d);     check({tag, " R10 pend w0 clr-rd"}, 64'(d), 64'(flat_pd[31:0]));
        rd(PS + 1, d); check({tag, " R10 pend w1 set-rd"}, 64'(d), 64'(flat_pd[63:32]));
        check({tag, " R7 irq_ready"}, 64'(irq_ready), 64'(en_m & pend_m));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(EC, d); check("R1 enable clr-rd w0", 64'(d), 0);
        rd(PS, d); check("R1 pend set-rd w0", 64'(d), 0);
        check_state("R1 reset");
    endtask

    task automatic t_enable;
        wr(ES, 32'h0000_00F0); en_m[7:4] = 4'hF;           check_state("R2 first set");
        wr(ES, 32'h0000_0001); en_m[0] = 1'b1;             check_state("R2 zeros keep");
        wr(EC, 32'h0000_0030); en_m[5:4] = 2'b00;          check_state("R3 clear");
        wr(ES + 1, 32'hFFFF_FFFF); en_m[39:32] = 8'hFF;    check_state("R10 upper bits read 0");
        wr(EC + 1, 32'h0000_0080); en_m[39] = 1'b0;        check_state("R3 word1 clear");
    endtask

    task automatic t_pend;
        wr(PS, 32'h0000_0300); pend_m[9:8] = 2'b11;        check_state("R4 pend set, R7 disabled kept");
        wr(ES, 32'h0000_0100); en_m[8] = 1'b1;             check_state("R7 enable exposes");
        wr(PC, 32'h0000_0200); pend_m[9] = 1'b0;           check_state("R5 unpend");
        wr(PS + 1, 32'h0000_0041); pend_m[32] = 1'b1; pend_m[38] = 1'b1; check_state("R4 word1");
    endtask

    task automatic t_request;
        @(negedge clk); irq_req[35] = 1'b1;
        @(negedge clk); pend_m[35] = 1'b1;                 check_state("R6 edge sets");
        wr(PC + 1, 32'h0000_0008); pend_m[35] = 1'b0;
        repeat (3) @(negedge clk);                         check_state("R6 held level no retrigger");
        @(negedge clk); irq_req[35] = 1'b0;
        @(negedge clk); irq_req[35] = 1'b1;
        @(negedge clk); pend_m[35] = 1'b1;                 check_state("R6 fresh edge sets again");
    endtask

    task automatic t_ack;
        @(negedge clk); ack_valid = 1'b1; ack_line = 6'd8;
        @(negedge clk); ack_valid = 1'b0; pend_m[8] = 1'b0;
        check_state("R8 ack line 8");
        @(negedge clk); ack_valid = 1'b1; ack_line = 6'd38;
        @(negedge clk); ack_valid = 1'b0; pend_m[38] = 1'b0;
        check_state("R8 ack line 38");
        wr(PS + 1, 32'h0000_00FF); pend_m[39:32] = 8'hFF;
        @(negedge clk); ack_valid = 1'b1; ack_line = 6'd45;
        @(negedge clk); ack_valid = 1'b0;
        check_state("R8 out of range ack ignored");
    endtask

    task automatic t_collide;
        @(negedge clk); irq_req[5] = 1'b1; ack_valid = 1'b1; ack_line = 6'd5;
        @(negedge clk); ack_valid = 1'b0; pend_m[5] = 1'b1;
        check_state("R9 edge vs ack");
        @(negedge clk); bus_wr = 1'b1; bus_addr = PS; bus_wdata = 32'h40;
        ack_valid = 1'b1; ack_line = 6'd6;
        @(negedge clk); bus_wr = 1'b0; ack_valid = 1'b0; pend_m[6] = 1'b1;
        check_state("R9 pend write vs ack");
        @(negedge clk); bus_wr = 1'b1; bus_addr = PC; bus_wdata = 32'h80; irq_req[7] = 1'b1;
        @(negedge clk); bus_wr = 1'b0; pend_m[7] = 1'b1;
        check_state("R9 edge vs unpend");
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        wr(ES + 2, 32'hFFFF_FFFF);
        wr(PS + 7, 32'hFFFF_FFFF);
        rd(ES + 2, d); check("R11 unmapped word reads 0", 64'(d), 0);
        rd(PC + 7, d); check("R11 unmapped pend word reads 0", 64'(d), 0);
        check_state("R11 unmapped writes ignored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_pend();
        t_request();
        t_ack();
        t_collide();
        t_unmapped();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule